// File: doc/BRIEF.md
# Time-Shared Single-Multiplier Recursive Filter

This block is a reconfigurable fixed-point recursive (IIR) filter in Direct Form II. It is meant for shaping complex white noise into a fading spectrum inside a channel emulator. A single signed multiplier with an accumulator produces every product of a sample. A small sequencer steps it first through the feedback terms and then through the feed-forward terms. One delay line of intermediate values serves both halves of the recursion.

Feed-forward coefficients, feedback coefficients and delayed states sit in three separate register banks, each 11 deep and 32 bits wide. The order is picked per sample, from 0 up to a parameter maximum of 5. Coefficients may be rewritten between samples, so one instance can serve many channel taps one after another. A sample is taken on an input strobe. An output strobe marks the cycle in which the rounded and saturated result is ready. A clock enable stretches the schedule when the filter should run slower than its clock.

Top module: `mac_iir_filter`

## Requirements
- R1: After reset, `busy` and `out_valid` are low, `out_data` is zero, and all delayed states and coefficients are zero.
- R2: For effective order N, each accepted sample x gives w = x − Σ a[k]·s[k−1] for k = 1..N, then y = b[0]·w + Σ b[k]·s[k−1]. Here s[0] holds the previous w, s[1] the one before it, and so on. After y is produced, w is shifted into s[0].
- R3: Coefficients are signed with 30 fraction bits (value = code / 2^30). Sums are exact in a wide accumulator. w and y are each rounded half up (add 2^29, then floor-divide by 2^30) and saturated to the 32-bit signed range.
- R4: `out_valid` rises after exactly 2·N+3 enabled clock edges following the enabled edge that accepts the sample. `out_data` keeps that result until the next result replaces it.
- R5: `busy` is high from the accepting edge until `out_valid` rises. `in_valid` is ignored while `busy` is high.
- R6: A write with `cfg_bank` = 0 sets b[`cfg_addr`], and a write with `cfg_bank` = 1 sets a[`cfg_addr`]. Addresses 0..10 are valid, and a[0] is never used. A write is ignored while `busy` is high.
- R7: `state_clr` on an enabled idle edge zeroes every delayed state and keeps the coefficients. It is ignored while `busy` is high.
- R8: While `clk_en` is low, no register changes, including `out_valid` and `out_data`.
- R9: `order_sel` is captured on the accepting edge. Values above 5 act as order 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Enables every register update |
| order_sel | input | 3 | Filter order for the next accepted sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_bank | input | 1 | 0 selects feed-forward b, 1 selects feedback a |
| cfg_addr | input | 4 | Coefficient index |
| cfg_data | input | 32 | Coefficient value, signed, 30 fraction bits |
| state_clr | input | 1 | Zero the delayed states |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 32 | Input sample, signed |
| busy | output | 1 | Sample in progress |
| out_valid | output | 1 | Result ready |
| out_data | output | 32 | Filter output, signed |

## Verification
A result is due on the (2·N+3)-th enabled edge after the edge that accepts the sample. The bench counts enabled edges from that accepting edge and requires `out_valid` to appear on exactly that count. It reads `out_data` at the falling edge that follows, and it does the same when `clk_en` is toggled at random mid-sample. Stimulus aimed at a busy filter (a second strobe, a coefficient write or a state clear) is applied on the first edge after acceptance. The check for it is the following result, which must equal the reference model in which that stimulus never happened.

// File: rtl/mac_iir_pkg.sv
package mac_iir_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_FB   = 3'd1,
      ST_WRND = 3'd2,
      ST_FF   = 3'd3,
      ST_YRND = 3'd4
   } seq_state_t;
endpackage

// File: rtl/mac_iir_coef_bank.sv
module mac_iir_coef_bank #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 11,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             allow,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("coef bank depth too small");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic wr_ok, rd_ok;

   assign wr_ok   = {1'b0, wr_addr} < (AW+1)'(DEPTH);
   assign rd_ok   = {1'b0, rd_addr} < (AW+1)'(DEPTH);
   assign rd_data = rd_ok ? mem_q[rd_addr] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (clk_en && allow && wr_en && wr_ok) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !allow && wr_ok) |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));
endmodule

// File: rtl/mac_iir_delay_line.sv
module mac_iir_delay_line #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 11,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             clr,
   input  logic             shift,
   input  logic [WIDTH-1:0] shift_in,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("delay line depth too small");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic rd_ok;

   assign rd_ok   = {1'b0, rd_addr} < (AW+1)'(DEPTH);
   assign rd_data = rd_ok ? mem_q[rd_addr] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (clk_en) begin
         if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (shift) begin
            mem_q[0] <= shift_in;
            for (int i = 1; i < DEPTH; i++) mem_q[i] <= mem_q[i-1];
         end
      end
   end

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && clr) |=> (mem_q[0] == '0 && mem_q[DEPTH-1] == '0));
   // R8
   state_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(mem_q[0]));
endmodule

// File: rtl/mac_iir_rndsat.sv
module mac_iir_rndsat #(
   parameter int ACC_W    = 72,
   parameter int OUT_W    = 32,
   parameter int FRAC     = 30,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc_in,
   output logic        [OUT_W-1:0] data_out
);
   if (FRAC < 1 || ACC_W <= OUT_W + FRAC) begin : g_bad_fmt
      $error("rndsat: accumulator too narrow for format");
   end

   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC-1);
   localparam logic signed [ACC_W-1:0] MAXV =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] biased, scaled;

   if (ROUND_EN) begin : g_round
      assign biased = acc_in + HALF;
   end else begin : g_trunc
      assign biased = acc_in;
   end

   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > MAXV)      data_out = MAXV[OUT_W-1:0];
      else if (scaled < MINV) data_out = MINV[OUT_W-1:0];
      else                    data_out = scaled[OUT_W-1:0];
   end
endmodule

// File: rtl/mac_iir_filter.sv
module mac_iir_filter #(
   parameter int DATA_W    = 32,
   parameter int COEF_FRAC = 30,
   parameter int MAX_ORDER = 5,
   parameter int MEM_DEPTH = 11,
   parameter int GUARD_W   = 8,
   parameter bit ROUND_EN  = 1'b1,
   parameter int AW        = $clog2(MEM_DEPTH),
   parameter int OW        = $clog2(MAX_ORDER + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic [OW-1:0]     order_sel,
   input  logic              cfg_we,
   input  logic              cfg_bank,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              state_clr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              busy,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   import mac_iir_pkg::*;

   localparam int PROD_W = 2 * DATA_W;
   localparam int ACC_W  = PROD_W + GUARD_W;
   localparam logic [OW-1:0] MAX_ORD_L = OW'(MAX_ORDER);

   if (MEM_DEPTH < MAX_ORDER + 1 || MAX_ORDER < 1) begin : g_bad_cfg
      $error("filter: memory depth does not cover the maximum order");
   end
   if (COEF_FRAC >= DATA_W) begin : g_bad_frac
      $error("filter: coefficient fraction too wide");
   end

   seq_state_t state_q;
   logic [AW-1:0]            k_q;
   logic [OW-1:0]            order_q, ord_eff;
   logic signed [ACC_W-1:0]  acc_q, mac_next, prod_ext;
   logic signed [PROD_W-1:0] prod;
   logic [DATA_W-1:0]        w_q, out_q, rs_out;
   logic [DATA_W-1:0]        ff_rd, fb_rd, st_rd, coef_op, data_op;
   logic                     idle, last_k, out_valid_q;

   assign idle    = (state_q == ST_IDLE);
   assign ord_eff = (order_sel > MAX_ORD_L) ? MAX_ORD_L : order_sel;
   assign last_k  = (k_q == AW'(order_q));

   mac_iir_coef_bank #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_ff_bank (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .allow(idle),
      .wr_en(cfg_we && !cfg_bank), .wr_addr(cfg_addr), .wr_data(cfg_data),
      .rd_addr(k_q), .rd_data(ff_rd));

   mac_iir_coef_bank #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_fb_bank (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .allow(idle),
      .wr_en(cfg_we && cfg_bank), .wr_addr(cfg_addr), .wr_data(cfg_data),
      .rd_addr(k_q), .rd_data(fb_rd));

   mac_iir_delay_line #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_states (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .clr(state_clr && idle), .shift(state_q == ST_YRND), .shift_in(w_q),
      .rd_addr(k_q - AW'(1)), .rd_data(st_rd));

   mac_iir_rndsat #(.ACC_W(ACC_W), .OUT_W(DATA_W), .FRAC(COEF_FRAC),
                    .ROUND_EN(ROUND_EN)) u_rndsat (
      .acc_in(acc_q), .data_out(rs_out));

   // the single multiplier and its add/subtract stage
   assign coef_op  = (state_q == ST_FB) ? fb_rd : ff_rd;
   assign data_op  = (state_q == ST_FF && k_q == '0) ? w_q : st_rd;
   assign prod     = $signed(coef_op) * $signed(data_op);
   assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
   assign mac_next = (state_q == ST_FB) ? (acc_q - prod_ext) : (acc_q + prod_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         k_q         <= '0;
         order_q     <= '0;
         acc_q       <= '0;
         w_q         <= '0;
         out_q       <= '0;
         out_valid_q <= 1'b0;
      end else if (clk_en) begin
         out_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (in_valid) begin
               acc_q   <= $signed({{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data}) <<< COEF_FRAC;
               order_q <= ord_eff;
               k_q     <= AW'(1);
               state_q <= (ord_eff == '0) ? ST_WRND : ST_FB;
            end
            ST_FB: begin
               acc_q <= mac_next;
               k_q   <= k_q + AW'(1);
               if (last_k) state_q <= ST_WRND;
            end
            ST_WRND: begin
               w_q     <= rs_out;
               acc_q   <= '0;
               k_q     <= '0;
               state_q <= ST_FF;
            end
            ST_FF: begin
               acc_q <= mac_next;
               k_q   <= k_q + AW'(1);
               if (last_k) state_q <= ST_YRND;
            end
            ST_YRND: begin
               out_q       <= rs_out;
               out_valid_q <= 1'b1;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = !idle;
   assign out_valid = out_valid_q;
   assign out_data  = out_q;

   // R5
   order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(order_q));
   // R4
   fb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FB) |-> (k_q >= AW'(1) && k_q <= AW'(order_q)));
   // R4
   valid_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && state_q == ST_YRND) |=> (out_valid && !busy));
   // R5
   busy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !busy);
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(state_q) && $stable(acc_q) && $stable(out_valid_q) && $stable(out_q)));
endmodule

// File: tb/tb_mac_iir_filter.sv
`timescale 1ns/1ps
module tb_mac_iir_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b1;
   logic [2:0]  order_sel = '0;
   logic        cfg_we = 1'b0, cfg_bank = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_data = '0;
   logic        state_clr = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        busy, out_valid;
   logic [31:0] out_data;

   int n_chk = 0, n_bad = 0;
   logic signed [31:0] m_ff [11];
   logic signed [31:0] m_fb [11];
   logic signed [31:0] m_st [11];

   always #4 clk = ~clk;

   mac_iir_filter dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .order_sel(order_sel),
      .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .state_clr(state_clr), .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .out_valid(out_valid), .out_data(out_data));

   function automatic logic signed [31:0] rsat(input logic signed [95:0] v);
      logic signed [95:0] t;
      t = (v + 96'sd536870912) >>> 30;
      if (t > 96'sd2147483647) return 32'sh7fffffff;
      if (t < -96'sd2147483648) return 32'sh80000000;
      return t[31:0];
   endfunction

   function automatic logic signed [31:0] model_step(input logic signed [31:0] x, input int ord);
      logic signed [95:0] acc;
      logic signed [31:0] w, y;
      acc = x;
      acc = acc <<< 30;
      for (int k = 1; k <= ord; k++) acc = acc - m_fb[k] * m_st[k-1];
      w = rsat(acc);
      acc = m_ff[0] * w;
      for (int k = 1; k <= ord; k++) acc = acc + m_ff[k] * m_st[k-1];
      y = rsat(acc);
      for (int i = 10; i > 0; i--) m_st[i] = m_st[i-1];
      m_st[0] = w;
      return y;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic prog(input bit bank, input int addr, input logic [31:0] val);
      @(negedge clk);
      while (busy) @(negedge clk);
      clk_en = 1'b1; cfg_we = 1'b1; cfg_bank = bank; cfg_addr = 4'(addr); cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
      if (bank) m_fb[addr] = val; else m_ff[addr] = val;
   endtask

   task automatic clear_states();
      @(negedge clk);
      while (busy) @(negedge clk);
      clk_en = 1'b1; state_clr = 1'b1;
      @(negedge clk);
      state_clr = 1'b0;
      for (int i = 0; i < 11; i++) m_st[i] = '0;
   endtask

   // inj: 0 none, 1 extra strobe, 2 coefficient write, 3 state clear (all while busy)
   task automatic send(input logic signed [31:0] x, input int ord, input bit gaps,
                       input int inj, input string tag, output logic signed [31:0] y_got);
      int eff, n;
      bit en, got;
      logic signed [31:0] y_exp;
      eff = (ord > 5) ? 5 : ord;
      @(negedge clk);
      while (busy) @(negedge clk);
      clk_en = 1'b1; order_sel = 3'(ord); in_valid = 1'b1; in_data = x;
      @(negedge clk);
      in_valid = 1'b0; in_data = $urandom;
      chk(busy == 1'b1, "R5 busy after accept", 64'(busy), 1);
      y_exp = model_step(x, eff);
      n = 0; got = 1'b0;
      for (int g = 0; g < 400 && !got; g++) begin
         en = gaps ? ($urandom % 3 != 0) : 1'b1;
         if (g == 0 && inj != 0) en = 1'b1;
         clk_en = en;
         if (g == 0) begin
            case (inj)
               1: begin in_valid = 1'b1; in_data = ~x; end
               2: begin cfg_we = 1'b1; cfg_bank = 1'b0; cfg_addr = 4'd0; cfg_data = 32'h3000_0000; end
               3: state_clr = 1'b1;
               default: ;
            endcase
         end
         @(negedge clk);
         in_valid = 1'b0; cfg_we = 1'b0; state_clr = 1'b0;
         if (en) n++;
         if (out_valid) got = 1'b1;
      end
      chk(got && n == 2*eff+3, "R4 latency", n, 2*eff+3);
      chk(out_data == y_exp, tag, $signed(out_data), y_exp);
      y_got = out_data;
      if (gaps) begin
         clk_en = 1'b0;
         @(negedge clk);
         chk(out_valid && out_data == y_exp, "R8 output held with clk_en low", $signed(out_data), y_exp);
      end
      clk_en = 1'b1;
      if (inj == 1) begin
         @(negedge clk);
         chk(!out_valid && !busy, "R5 strobe while busy ignored", 64'(busy), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic signed [31:0] y;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 11; i++) begin m_ff[i] = '0; m_fb[i] = '0; m_st[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!busy && !out_valid && out_data == '0, "R1 reset outputs", $signed(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all-zero coefficients give zero output
      send(32'sd5000, 5, 1'b0, 0, "R1 zero coefficients", y);

      // R2 order 0, unity gain
      prog(1'b0, 0, 32'h4000_0000);
      send(32'sd12345, 0, 1'b0, 0, "R2 order0 pass", y);
      chk(y == 32'sd12345, "R2 unity gain", y, 12345);
      send(-32'sd777, 0, 1'b0, 0, "R2 order0 negative", y);

      // R3 rounding half up and saturation
      prog(1'b0, 0, 32'h2000_0000);
      send(32'sd3, 0, 1'b0, 0, "R3 round +1.5", y);
      chk(y == 32'sd2, "R3 round +1.5 up", y, 2);
      send(-32'sd3, 0, 1'b0, 0, "R3 round -1.5", y);
      chk(y == -32'sd1, "R3 round -1.5 up", y, -1);
      prog(1'b0, 0, 32'h7fff_ffff);
      send(32'sh7fff_ffff, 0, 1'b0, 0, "R3 saturate high", y);
      chk(y == 32'sh7fff_ffff, "R3 saturate high value", y, 32'sh7fff_ffff);
      send(32'sh8000_0000, 0, 1'b0, 0, "R3 saturate low", y);
      chk(y == 32'sh8000_0000, "R3 saturate low value", y, 32'sh8000_0000);

      // R2 random coefficients, all orders
      for (int i = 0; i <= 5; i++) prog(1'b0, i, 32'(int'($urandom % (1 << 29)) - (1 << 28)));
      for (int i = 1; i <= 5; i++) prog(1'b1, i, 32'(int'($urandom % (1 << 27)) - (1 << 26)));
      clear_states();
      send(32'sd1000000, 5, 1'b0, 0, "R2 impulse order5", y);
      for (int s = 0; s < 30; s++)
         send($signed($urandom), int'($urandom % 6), 1'b0, 0, "R2 random sample", y);

      // R9 out-of-range order acts as maximum
      send($signed($urandom), 7, 1'b0, 0, "R9 order 7 as 5", y);
      send($signed($urandom), 6, 1'b0, 0, "R9 order 6 as 5", y);

      // R8 clock enable gaps
      for (int s = 0; s < 12; s++)
         send($signed($urandom), int'($urandom % 6), 1'b1, 0, "R8 gapped sample", y);

      // R5 extra strobe while busy
      send(32'sd424242, 4, 1'b0, 1, "R5 sample with extra strobe", y);
      send(32'sd100, 4, 1'b0, 0, "R5 no stray sample taken", y);

      // R6 coefficient writes: feedback bank, then write while busy
      prog(1'b1, 3, 32'hfe00_0000);
      send(32'sd777777, 5, 1'b0, 0, "R6 feedback write used", y);
      send(32'sd2222, 5, 1'b0, 2, "R6 sample with write while busy", y);
      send(32'sd98765, 5, 1'b0, 0, "R6 busy write ignored", y);

      // R7 clear while busy ignored, then idle clear
      send(32'sd55555, 3, 1'b0, 3, "R7 sample with clear while busy", y);
      send(32'sd4444, 3, 1'b0, 0, "R7 busy clear ignored", y);
      clear_states();
      send(32'sd65536, 5, 1'b0, 0, "R7 after clear", y);
      send(32'sd0, 5, 1'b0, 0, "R7 ringing after clear", y);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule